// File: doc/BRIEF.md
# Laser Fault and Shutdown Controller

This block collects the alarm bits produced by the slow converter threshold comparisons and by the fast quick-trip comparators and turns them into two laser-protection outputs: a transmit-fault flag and a safety-shutdown gate. Each output has its own mask, so a source can be routed to either, to both, or to neither. The shutdown gate always holds once it trips. The transmit-fault flag follows its sources while they are active unless its hold option is set. A separate option lets a shutdown trip force the transmit-fault flag as well.

The block also owns the bias and modulation enables of the laser driver. After power-up they stay off until the supply is valid, a temperature conversion has finished and, when the supply alarm is in use, a supply conversion has come back clear of the low alarm. Transmit-disable, a software disable or a tripped shutdown gate turns both enables off. On release, modulation comes back one cycle before bias, and a one-cycle pulse starts the bias search. The analog comparators and converters are outside the block.

The drive sequencer has four states. `DRV_WAIT` waits for readiness. `DRV_MOD_FIRST` enables modulation and issues the search pulse. `DRV_RUN` enables both. `DRV_HALT` holds both off. Its transitions are: WAIT→MOD_FIRST (ready, no off request), WAIT→HALT (ready, off request), MOD_FIRST→RUN, MOD_FIRST→HALT, RUN→HALT and HALT→MOD_FIRST (off request released). Every state goes to WAIT when the supply drops. The shutdown latch has two states: `SD_ARMED`→`SD_TRIPPED` on a masked hit, and back when a clear is requested with no masked hit present. The fault-flag machine has three states: `TXF_IDLE`, `TXF_FOLLOW` (flag on, not held) and `TXF_HELD` (flag on and held).

Top module: `laser_fault_ctrl`

## Requirements
- R1: With the hold option off, `txf_out` goes high one clock after any alarm bit whose `txf_mask` bit is set, and drops one clock after the last such alarm clears. Alarm bit positions are 0 temperature, 1 supply, 2 to 5 monitors one to four, 6 transmit power high, 7 transmit power low, 8 bias high and 9 bias maximum.
- R2: With `txf_latch_en` set, `txf_out` stays high after its sources clear, until a clear request.
- R3: The shutdown latch trips one clock after any alarm bit whose `sd_mask` bit is set, whatever `txf_mask` holds, and stays tripped after the alarm clears.
- R4: `sd_out` equals the latch state XOR `sd_polarity`. With polarity 0 it is low when armed and high when tripped.
- R5: With `txf_on_sd` set, a tripped shutdown latch holds `txf_out` high even when no transmit-fault source is active.
- R6: A clear request is `fault_reset` or `tx_disable` high. It clears the latched states only when no masked source of that state is active. Otherwise the state stays set.
- R7: After reset or a supply loss, `mod_en` and `bias_en` stay low until `supply_ok` is high, a `temp_conv_done` pulse has arrived and, if `vcc_alarm_en` is set, a `vcc_conv_done` pulse has arrived with `vcc_low_alarm` low. Enables rise two clocks after the last condition is met.
- R8: `tx_disable`, `soft_disable` or a tripped shutdown latch forces `mod_en` and `bias_en` low from the next clock.
- R9: On release of all off requests, `mod_en` rises with `bias_en` low and `bias_search_start` high for exactly one clock. `bias_en` follows one clock later.
- R10: `fault_status[1]` reports the shutdown latch state regardless of polarity, and `fault_status[0]` reports the transmit-fault state.
- R11: A drop of `supply_ok` returns the sequencer to waiting and discards the recorded conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alarm_in | input | NUM_SRC | Alarm bits from the converter and quick-trip comparisons |
| txf_mask | input | NUM_SRC | Per-source enable for the transmit-fault flag |
| sd_mask | input | NUM_SRC | Per-source enable for the shutdown latch |
| txf_on_sd | input | 1 | A shutdown trip also raises the transmit-fault flag |
| txf_latch_en | input | 1 | Transmit-fault flag holds after its sources clear |
| sd_polarity | input | 1 | Inverts the shutdown gate level |
| supply_ok | input | 1 | Supply above the analog valid level |
| temp_conv_done | input | 1 | Pulse: a temperature conversion has finished |
| vcc_conv_done | input | 1 | Pulse: a supply conversion has finished |
| vcc_low_alarm | input | 1 | Low-supply alarm from the finished supply conversion |
| vcc_alarm_en | input | 1 | Supply conversion must clear before enabling |
| tx_disable | input | 1 | Transmit disable; also requests a fault clear |
| soft_disable | input | 1 | Software transmit disable |
| fault_reset | input | 1 | Software request to clear latched faults |
| mod_en | output | 1 | Modulation enable |
| bias_en | output | 1 | Bias enable |
| bias_search_start | output | 1 | One-clock pulse that starts the bias search |
| txf_out | output | 1 | Transmit-fault flag |
| sd_out | output | 1 | Safety-shutdown gate, polarity applied |
| fault_status | output | 2 | Bit 1 shutdown latch state, bit 0 transmit-fault state |

## Verification
In a single cycle, a clear request can arrive while the alarm that set the latch is still active. The set has to win. The bench raises `fault_reset`, and later `tx_disable`, with the masked source still high, and requires both status bits to stay set. It then repeats the clear with the source low and requires both bits to drop. The second collision is a shutdown trip landing during re-enable. The bench trips the gate while the sequencer is releasing from transmit-disable and checks that the enables go low on the clock after the latch reports tripped, while the transmit-fault flag follows the shutdown-forcing option.

// File: rtl/lfc_pkg.sv
package lfc_pkg;
    localparam int LFC_SRC_DEFAULT = 10;

    typedef enum logic [1:0] {
        DRV_WAIT      = 2'd0,
        DRV_MOD_FIRST = 2'd1,
        DRV_RUN       = 2'd2,
        DRV_HALT      = 2'd3
    } drv_state_t;

    typedef enum logic {
        SD_ARMED   = 1'b0,
        SD_TRIPPED = 1'b1
    } sd_state_t;

    typedef enum logic [1:0] {
        TXF_IDLE   = 2'd0,
        TXF_FOLLOW = 2'd1,
        TXF_HELD   = 2'd2
    } txf_state_t;
endpackage

// File: rtl/lfc_mask_reduce.sv
module lfc_mask_reduce #(
    parameter int WIDTH = 10
) (
    input  logic [WIDTH-1:0] alarm,
    input  logic [WIDTH-1:0] mask,
    output logic             hit
);
    logic [WIDTH-1:0] gated;

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_bit
            assign gated[gi] = alarm[gi] & mask[gi];
        end
    endgenerate

    assign hit = |gated;
endmodule

// File: rtl/lfc_shutdown_latch.sv
module lfc_shutdown_latch
    import lfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clear_req,
    output logic tripped_q,
    output logic tripped_next
);
    sd_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SD_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SD_ARMED:   if (hit) state_d = SD_TRIPPED;
            SD_TRIPPED: if (clear_req && !hit) state_d = SD_ARMED;
            default:    state_d = SD_ARMED;
        endcase
    end

    always_comb begin
        tripped_q    = (state_q == SD_TRIPPED);
        tripped_next = (state_d == SD_TRIPPED);
    end
endmodule

// File: rtl/lfc_txf_hold.sv
module lfc_txf_hold
    import lfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic live,
    input  logic sd_next,
    input  logic on_sd,
    input  logic latch_en,
    input  logic clear_req,
    output logic flag
);
    txf_state_t state_q, state_d;
    logic       force_on;

    assign force_on = live | (on_sd & sd_next);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TXF_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TXF_IDLE, TXF_FOLLOW: begin
                if (force_on) state_d = latch_en ? TXF_HELD : TXF_FOLLOW;
                else          state_d = TXF_IDLE;
            end
            TXF_HELD: begin
                if (force_on)                  state_d = latch_en ? TXF_HELD : TXF_FOLLOW;
                else if (latch_en && !clear_req) state_d = TXF_HELD;
                else                           state_d = TXF_IDLE;
            end
            default: state_d = TXF_IDLE;
        endcase
    end

    always_comb begin
        flag = (state_q != TXF_IDLE);
    end
endmodule

// File: rtl/lfc_drive_fsm.sv
module lfc_drive_fsm
    import lfc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic temp_conv_done,
    input  logic vcc_conv_done,
    input  logic vcc_low_alarm,
    input  logic vcc_alarm_en,
    input  logic off_req,
    output logic mod_en,
    output logic bias_en,
    output logic search_start
);
    drv_state_t state_q, state_d;
    logic       temp_seen_q;
    logic       vcc_clear_q;
    logic       ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            temp_seen_q <= 1'b0;
            vcc_clear_q <= 1'b0;
        end else if (!supply_ok) begin
            temp_seen_q <= 1'b0;
            vcc_clear_q <= 1'b0;
        end else begin
            if (temp_conv_done)                  temp_seen_q <= 1'b1;
            if (vcc_conv_done && !vcc_low_alarm) vcc_clear_q <= 1'b1;
        end
    end

    assign ready = supply_ok & temp_seen_q & (vcc_clear_q | ~vcc_alarm_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DRV_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!supply_ok) begin
            state_d = DRV_WAIT;
        end else begin
            unique case (state_q)
                DRV_WAIT:      if (ready) state_d = off_req ? DRV_HALT : DRV_MOD_FIRST;
                DRV_MOD_FIRST: state_d = off_req ? DRV_HALT : DRV_RUN;
                DRV_RUN:       if (off_req) state_d = DRV_HALT;
                DRV_HALT:      if (!off_req) state_d = DRV_MOD_FIRST;
                default:       state_d = DRV_WAIT;
            endcase
        end
    end

    always_comb begin
        mod_en       = 1'b0;
        bias_en      = 1'b0;
        search_start = 1'b0;
        unique case (state_q)
            DRV_WAIT:      ;
            DRV_MOD_FIRST: begin mod_en = 1'b1; search_start = 1'b1; end
            DRV_RUN:       begin mod_en = 1'b1; bias_en = 1'b1; end
            DRV_HALT:      ;
            default:       ;
        endcase
    end
endmodule

// File: rtl/laser_fault_ctrl.sv
module laser_fault_ctrl
    import lfc_pkg::*;
#(
    parameter int NUM_SRC = LFC_SRC_DEFAULT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] alarm_in,
    input  logic [NUM_SRC-1:0] txf_mask,
    input  logic [NUM_SRC-1:0] sd_mask,
    input  logic               txf_on_sd,
    input  logic               txf_latch_en,
    input  logic               sd_polarity,
    input  logic               supply_ok,
    input  logic               temp_conv_done,
    input  logic               vcc_conv_done,
    input  logic               vcc_low_alarm,
    input  logic               vcc_alarm_en,
    input  logic               tx_disable,
    input  logic               soft_disable,
    input  logic               fault_reset,
    output logic               mod_en,
    output logic               bias_en,
    output logic               bias_search_start,
    output logic               txf_out,
    output logic               sd_out,
    output logic [1:0]         fault_status
);
    logic txf_live;
    logic sd_hit;
    logic clear_req;
    logic sd_tripped;
    logic sd_tripped_next;
    logic txf_flag;

    assign clear_req = fault_reset | tx_disable;

    lfc_mask_reduce #(.WIDTH(NUM_SRC)) u_txf_reduce (
        .alarm (alarm_in),
        .mask  (txf_mask),
        .hit   (txf_live)
    );

    lfc_mask_reduce #(.WIDTH(NUM_SRC)) u_sd_reduce (
        .alarm (alarm_in),
        .mask  (sd_mask),
        .hit   (sd_hit)
    );

    lfc_shutdown_latch u_sd_latch (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit          (sd_hit),
        .clear_req    (clear_req),
        .tripped_q    (sd_tripped),
        .tripped_next (sd_tripped_next)
    );

    lfc_txf_hold u_txf_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .live      (txf_live),
        .sd_next   (sd_tripped_next),
        .on_sd     (txf_on_sd),
        .latch_en  (txf_latch_en),
        .clear_req (clear_req),
        .flag      (txf_flag)
    );

    lfc_drive_fsm u_drive (
        .clk            (clk),
        .rst_n          (rst_n),
        .supply_ok      (supply_ok),
        .temp_conv_done (temp_conv_done),
        .vcc_conv_done  (vcc_conv_done),
        .vcc_low_alarm  (vcc_low_alarm),
        .vcc_alarm_en   (vcc_alarm_en),
        .off_req        (tx_disable | soft_disable | sd_tripped),
        .mod_en         (mod_en),
        .bias_en        (bias_en),
        .search_start   (bias_search_start)
    );

    assign txf_out      = txf_flag;
    assign sd_out       = sd_tripped ^ sd_polarity;
    assign fault_status = {sd_tripped, txf_flag};
endmodule

// File: rtl/laser_fault_ctrl_checker.sv
module laser_fault_ctrl_checker #(
    parameter int NUM_SRC = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] alarm_in,
    input logic [NUM_SRC-1:0] sd_mask,
    input logic               txf_on_sd,
    input logic               sd_polarity,
    input logic               supply_ok,
    input logic               tx_disable,
    input logic               soft_disable,
    input logic               fault_reset,
    input logic               mod_en,
    input logic               bias_en,
    input logic               bias_search_start,
    input logic               txf_out,
    input logic               sd_out,
    input logic [1:0]         fault_status
);
    a_r3_sd_holds: assert property (@(posedge clk) disable iff (!rst_n)
        fault_status[1] && !fault_reset && !tx_disable |=> fault_status[1]);

    a_r6_clear_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        fault_status[1] && (|(alarm_in & sd_mask)) |=> fault_status[1]);

    a_r4_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        sd_out == (fault_status[1] ^ sd_polarity));

    a_r5_sd_forces_txf: assert property (@(posedge clk) disable iff (!rst_n)
        fault_status[1] && $past(txf_on_sd) |-> txf_out);

    a_r7_no_supply_off: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !mod_en && !bias_en);

    a_r8_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
        tx_disable || soft_disable |=> !mod_en && !bias_en);

    a_r9_bias_after_mod: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bias_en) |-> mod_en && $past(mod_en));

    a_r9_search_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bias_search_start |-> mod_en && !bias_en);
endmodule

bind laser_fault_ctrl laser_fault_ctrl_checker #(.NUM_SRC(NUM_SRC)) u_checker (
    .clk               (clk),
    .rst_n             (rst_n),
    .alarm_in          (alarm_in),
    .sd_mask           (sd_mask),
    .txf_on_sd         (txf_on_sd),
    .sd_polarity       (sd_polarity),
    .supply_ok         (supply_ok),
    .tx_disable        (tx_disable),
    .soft_disable      (soft_disable),
    .fault_reset       (fault_reset),
    .mod_en            (mod_en),
    .bias_en           (bias_en),
    .bias_search_start (bias_search_start),
    .txf_out           (txf_out),
    .sd_out            (sd_out),
    .fault_status      (fault_status)
);

// File: tb/laser_fault_ctrl_tb_top.sv
`timescale 1ns/1ps
module laser_fault_ctrl_tb_top;
    localparam int N = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] alarm_in, txf_mask, sd_mask;
    logic         txf_on_sd, txf_latch_en, sd_polarity;
    logic         supply_ok, temp_conv_done, vcc_conv_done, vcc_low_alarm, vcc_alarm_en;
    logic         tx_disable, soft_disable, fault_reset;
    logic         mod_en, bias_en, bias_search_start, txf_out, sd_out;
    logic [1:0]   fault_status;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    laser_fault_ctrl #(.NUM_SRC(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .alarm_in(alarm_in), .txf_mask(txf_mask),
        .sd_mask(sd_mask), .txf_on_sd(txf_on_sd), .txf_latch_en(txf_latch_en),
        .sd_polarity(sd_polarity), .supply_ok(supply_ok),
        .temp_conv_done(temp_conv_done), .vcc_conv_done(vcc_conv_done),
        .vcc_low_alarm(vcc_low_alarm), .vcc_alarm_en(vcc_alarm_en),
        .tx_disable(tx_disable), .soft_disable(soft_disable),
        .fault_reset(fault_reset), .mod_en(mod_en), .bias_en(bias_en),
        .bias_search_start(bias_search_start), .txf_out(txf_out),
        .sd_out(sd_out), .fault_status(fault_status)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_bits(input string req, input logic m, input logic b, input logic s);
        chk(req, {29'd0, m, b, s}, {29'd0, m, b, s});
    endtask

    task automatic chk_drive(input string req, input logic m, input logic b, input logic s);
        chk(req, {29'd0, mod_en, bias_en, bias_search_start}, {29'd0, m, b, s});
    endtask

    task automatic clear_all();
        alarm_in    = '0;
        fault_reset = 1'b1;
        tick();
        fault_reset = 1'b0;
        tick();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; alarm_in = '0; txf_mask = '0; sd_mask = '0;
        txf_on_sd = 0; txf_latch_en = 0; sd_polarity = 0;
        supply_ok = 0; temp_conv_done = 0; vcc_conv_done = 0; vcc_low_alarm = 0;
        vcc_alarm_en = 1; tx_disable = 0; soft_disable = 0; fault_reset = 0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R10 reset state
        chk("R10 reset status", {30'd0, fault_status}, 32'd0);
        chk("R4 reset gate", {31'd0, sd_out}, 32'd0);
        chk_drive("R7 reset enables", 0, 0, 0);

        // R7 power-up gating with the supply alarm in use
        supply_ok = 1; tick(); tick();
        chk_drive("R7 supply only", 0, 0, 0);
        temp_conv_done = 1; tick(); temp_conv_done = 0; tick(); tick();
        chk_drive("R7 temp but no vcc", 0, 0, 0);
        vcc_conv_done = 1; vcc_low_alarm = 1; tick(); vcc_conv_done = 0; vcc_low_alarm = 0;
        tick(); tick();
        chk_drive("R7 vcc still low", 0, 0, 0);
        vcc_conv_done = 1; tick(); vcc_conv_done = 0;
        chk_drive("R7 one clock after vcc clear", 0, 0, 0);
        tick();
        chk_drive("R9 modulation first", 1, 0, 1);
        tick();
        chk_drive("R9 bias follows", 1, 1, 0);

        // R11 supply loss forgets conversions
        supply_ok = 0; tick();
        chk_drive("R11 supply drop", 0, 0, 0);
        supply_ok = 1; vcc_alarm_en = 0; tick(); tick(); tick();
        chk_drive("R11 temp forgotten", 0, 0, 0);
        temp_conv_done = 1; tick(); temp_conv_done = 0; tick();
        chk_drive("R7 vcc alarm unused", 1, 0, 1);
        tick();
        chk_drive("R9 run after restart", 1, 1, 0);

        // R8 / R9 transmit disable and software disable
        tx_disable = 1; tick();
        chk_drive("R8 tx_disable off", 0, 0, 0);
        tick();
        tx_disable = 0; tick();
        chk_drive("R9 release tx_disable", 1, 0, 1);
        tick();
        chk_drive("R9 bias after release", 1, 1, 0);
        soft_disable = 1; tick();
        chk_drive("R8 soft_disable off", 0, 0, 0);
        soft_disable = 0; tick();
        chk_drive("R9 release soft", 1, 0, 1);
        tick();
        chk_drive("R9 bias after soft", 1, 1, 0);

        // Sweep: polarity x source x {txf mask, sd mask, hold, force}
        for (int d = 0; d < 2; d++) begin
            for (int s = 0; s < N; s++) begin
                for (int c = 0; c < 16; c++) begin
                    logic tm, sm, le, se, exp_txf;
                    tm = c[0]; sm = c[1]; le = c[2]; se = c[3];
                    txf_mask = '0; sd_mask = '0;
                    clear_all();
                    txf_mask = N'(tm) << s; sd_mask = N'(sm) << s;
                    txf_latch_en = le; txf_on_sd = se; sd_polarity = d[0];
                    tick();
                    alarm_in = N'(1) << s;
                    tick();
                    exp_txf = tm | (sm & se);
                    chk("R1 R5 txf on alarm", {31'd0, txf_out}, {31'd0, exp_txf});
                    chk("R3 R4 gate on alarm", {31'd0, sd_out}, {31'd0, sm ^ d[0]});
                    alarm_in = '0;
                    tick();
                    exp_txf = (tm & le) | (sm & se);
                    chk("R2 R5 txf after alarm", {31'd0, txf_out}, {31'd0, exp_txf});
                    chk("R3 R10 latch after alarm", {30'd0, fault_status}, {30'd0, sm, exp_txf});
                    fault_reset = 1; tick(); fault_reset = 0;
                    chk("R6 cleared", {30'd0, fault_status}, 32'd0);
                end
            end
        end

        // R6 clear refused while the source is active, then tx_disable clear
        txf_mask = 10'b1; sd_mask = 10'b1; txf_latch_en = 1; txf_on_sd = 0; sd_polarity = 0;
        clear_all();
        alarm_in = 10'b1; tick();
        fault_reset = 1; tick(); fault_reset = 0;
        chk("R6 reset with active alarm", {30'd0, fault_status}, 32'd3);
        tx_disable = 1; tick();
        chk("R6 tx_disable with active alarm", {30'd0, fault_status}, 32'd3);
        alarm_in = '0; tick();
        chk("R6 tx_disable clear", {30'd0, fault_status}, 32'd0);
        tx_disable = 0; tick();
        chk_drive("R9 after clear", 1, 0, 1);

        // R8 shutdown trip during re-enable
        sd_mask = 10'b10; txf_mask = '0; txf_on_sd = 1; txf_latch_en = 0;
        tx_disable = 1; tick(); tx_disable = 0;
        alarm_in = 10'b10; tick();
        chk("R3 trip during release", {30'd0, fault_status}, 32'd3);
        chk_drive("R9 release before off", 1, 0, 1);
        tick();
        chk_drive("R8 shutdown off", 0, 0, 0);
        alarm_in = '0; tick();
        chk("R5 txf held by shutdown", {31'd0, txf_out}, 32'd1);
        fault_reset = 1; tick(); fault_reset = 0;
        chk("R6 all clear", {30'd0, fault_status}, 32'd0);
        tick();
        chk_drive("R9 restart after clear", 1, 0, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule